// File: doc/BRIEF.md
# Sampling ADC Conversion Start and Status Control

This block is the digital control side of a sampling converter, written as synchronous logic. It watches a mode pin, an active-low chip select and an active-low start-convert line, and decides on each clock whether a conversion begins. A conversion begins only on a high-to-low step of the start line. In synchronous mode, chip select must also be low when that step arrives. In asynchronous mode, chip select plays no part in starting a conversion.

A counter stands in for the conversion time. While it runs, the end-of-convert status is low. The counter length is a parameter in clock cycles.

The track/hold indicator goes to hold when a conversion starts. It returns to track a fixed number of cycles later, while the conversion is still running, so that the next acquisition overlaps the current conversion. At the start of a conversion the block captures the sample present at its input. When the conversion ends, the captured sample moves into the result register.

The status pin is modelled as a value plus two enables, one for each mode:
- In synchronous mode, the pin is a three-state driver, enabled by chip select together with a status-enable input.
- In asynchronous mode, the pin is open-drain. A drive-low enable stands for the pull-down.

After reset, the block ignores start requests for a configurable power-up interval.

Top module: `adc_start_ctrl`

## Requirements
- R1: With syncMode=1, a cycle where scN was 1 on the previous clock and is 0 now, while csN=0, starts a conversion. eocOut reads 0 from the following clock.
- R2: With syncMode=1, a falling step on scN while csN=1 starts no conversion. eocOut stays 1.
- R3: With syncMode=0, a falling step on scN starts a conversion whether csN is 0 or 1.
- R4: Holding scN at 0 starts at most one conversion. Another conversion needs scN to return to 1 and fall again.
- R5: A falling step on scN while a conversion is running is ignored. The status returns to 1 when the first conversion ends and stays 1.
- R6: holdOut is 1 for exactly HOLD_CYCLES clocks starting at the clock after the start. It is then 0 (track) for the rest of the conversion and while idle.
- R7: eocOut is 0 for exactly CONV_CYCLES clocks after a start. On the clock it returns to 1, resultOut takes the value sampleIn had in the start cycle. resultOut does not change at any other time.
- R8: eocDriveEn is 1 exactly when syncMode=1, csN=0 and eocEnN=0. The driven value eocOut is 0 while converting and 1 otherwise.
- R9: eocPullLow is 1 exactly when syncMode=0, eocEnN=0 and a conversion is running. eocDriveEn and eocPullLow are never 1 together.
- R10: For the first PWRUP_CYCLES clocks after rstN is released, no falling step on scN starts a conversion.
- R11: While rstN=0: eocOut=1, holdOut=0, resultOut=0 and eocPullLow=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncMode | input | 1 | 1 = synchronous mode (chip select gates start and status), 0 = asynchronous mode |
| csN | input | 1 | Active-low chip select |
| scN | input | 1 | Active-low start-convert line, falling step starts |
| eocEnN | input | 1 | Active-low enable for the status pin |
| sampleIn | input | DATA_W | Sample value captured at start |
| holdOut | output | 1 | 1 = hold, 0 = track |
| eocOut | output | 1 | Status value, 0 while converting |
| eocDriveEn | output | 1 | Three-state enable for the status pin (synchronous mode) |
| eocPullLow | output | 1 | Drive-low enable for the open-drain status pin (asynchronous mode) |
| resultOut | output | DATA_W | Result register |

## Verification
The hardest case to reach from the ports is a start line that falls or stays low in ways that must not create a conversion. Three situations are covered:
- A falling step that lands during the power-up interval.
- A second falling step while a conversion is already running.
- A start line held low across the end of one conversion, where a level-sensitive design would start again at once.

The stimulus covers each situation with scN pulses and long holds placed at those moments. A cycle-by-cycle model in the bench tracks edge history, conversion and hold countdowns, and the captured sample, so every clock compares status, hold, result and both pin enables.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef struct packed {
    logic startConv;
    logic endConv;
  } convStrobe_t;
endpackage

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int CONV_CYCLES  = 20,
  parameter int HOLD_CYCLES  = 4,
  parameter int PWRUP_CYCLES = 1250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncMode,
  input  logic        csN,
  input  logic        scN,
  output convStrobe_t strobe,
  output logic        busy,
  output logic        hold
);
  localparam int CNT_W  = $clog2(CONV_CYCLES + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam int PWR_W  = $clog2(PWRUP_CYCLES + 1);

  logic             scPrev;
  logic             pwrDone;
  logic [CNT_W-1:0] convCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic             fallSeen;
  logic             modeOk;

  always_ff @(posedge clk) begin
    if (!rstN) scPrev <= 1'b1;
    else       scPrev <= scN;
  end

  generate
    if (PWRUP_CYCLES == 0) begin : g_noPwr
      assign pwrDone = 1'b1;
    end else begin : g_pwr
      logic [PWR_W-1:0] pwrCnt;
      always_ff @(posedge clk) begin
        if (!rstN)
          pwrCnt <= '0;
        else if (pwrCnt != PWR_W'(PWRUP_CYCLES))
          pwrCnt <= pwrCnt + 1'b1;
      end
      assign pwrDone = (pwrCnt == PWR_W'(PWRUP_CYCLES));
    end
  endgenerate

  assign fallSeen         = scPrev & ~scN;
  assign modeOk           = ~syncMode | ~csN;
  assign strobe.startConv = pwrDone & fallSeen & modeOk & ~busy;
  assign strobe.endConv   = busy & (convCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      convCnt <= '0;
    end else if (strobe.startConv) begin
      busy    <= 1'b1;
      convCnt <= CNT_W'(CONV_CYCLES - 1);
    end else if (strobe.endConv) begin
      busy    <= 1'b0;
    end else if (busy) begin
      convCnt <= convCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hold    <= 1'b0;
      holdCnt <= '0;
    end else if (strobe.startConv) begin
      hold    <= 1'b1;
      holdCnt <= HOLD_W'(HOLD_CYCLES - 1);
    end else if (hold) begin
      if (holdCnt == '0) hold <= 1'b0;
      else               holdCnt <= holdCnt - 1'b1;
    end
  end

  assert_hold_inside_conv_R6: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> busy);

  assert_powerup_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDone |-> !busy);

  assert_fresh_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(scPrev) && !$past(scN)));

  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!$past(syncMode) || !$past(csN)));
endmodule

// File: rtl/adc_conv_datapath.sv
module adc_conv_datapath
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  convStrobe_t       strobe,
  input  logic              busy,
  input  logic              syncMode,
  input  logic              csN,
  input  logic              eocEnN,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              eocOut,
  output logic              eocDriveEn,
  output logic              eocPullLow
);
  logic [DATA_W-1:0] sampleReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleReg <= '0;
      resultOut <= '0;
    end else begin
      if (strobe.startConv) sampleReg <= sampleIn;
      if (strobe.endConv)   resultOut <= sampleReg;
    end
  end

  assign eocOut     = ~busy;
  assign eocDriveEn = syncMode & ~csN & ~eocEnN;
  assign eocPullLow = ~syncMode & ~eocEnN & busy;

  assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.endConv) |-> $stable(resultOut));

  assert_pins_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(eocDriveEn && eocPullLow));
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int CONV_CYCLES  = 20,
  parameter int HOLD_CYCLES  = 4,
  parameter int PWRUP_CYCLES = 1250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMode,
  input  logic              csN,
  input  logic              scN,
  input  logic              eocEnN,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              holdOut,
  output logic              eocOut,
  output logic              eocDriveEn,
  output logic              eocPullLow,
  output logic [DATA_W-1:0] resultOut
);
  convStrobe_t strobe;
  logic        busy;

  adc_conv_ctrl #(
    .CONV_CYCLES (CONV_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES),
    .PWRUP_CYCLES(PWRUP_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncMode(syncMode),
    .csN     (csN),
    .scN     (scN),
    .strobe  (strobe),
    .busy    (busy),
    .hold    (holdOut)
  );

  adc_conv_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .syncMode  (syncMode),
    .csN       (csN),
    .eocEnN    (eocEnN),
    .sampleIn  (sampleIn),
    .resultOut (resultOut),
    .eocOut    (eocOut),
    .eocDriveEn(eocDriveEn),
    .eocPullLow(eocPullLow)
  );
endmodule

// File: tb/adc_start_ctrl_tb.sv
`timescale 1ns/1ps
module adc_start_ctrl_tb;
  localparam int DW   = 14;
  localparam int CONV = 12;
  localparam int HOLD = 3;
  localparam int PWR  = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncMode = 1'b1, csN = 1'b1, scN = 1'b1, eocEnN = 1'b1;
  logic [DW-1:0] sampleIn = '0;
  logic holdOut, eocOut, eocDriveEn, eocPullLow;
  logic [DW-1:0] resultOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_start_ctrl #(.DATA_W(DW), .CONV_CYCLES(CONV), .HOLD_CYCLES(HOLD),
                   .PWRUP_CYCLES(PWR)) u_dut (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .csN(csN), .scN(scN),
    .eocEnN(eocEnN), .sampleIn(sampleIn), .holdOut(holdOut), .eocOut(eocOut),
    .eocDriveEn(eocDriveEn), .eocPullLow(eocPullLow), .resultOut(resultOut));

  // behavioural reference
  int pu = 0, busyLeft = 0, holdLeft = 0;
  bit scLast = 1'b1;
  logic [DW-1:0] capM = '0, resM = '0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      pu = 0; busyLeft = 0; holdLeft = 0; scLast = 1'b1; capM = '0; resM = '0;
    end else begin
      bit go;
      go = (pu >= PWR) && scLast && !scN && busyLeft == 0 && (!syncMode || !csN);
      if (busyLeft > 0) begin
        busyLeft--;
        if (busyLeft == 0) resM = capM;
      end
      if (holdLeft > 0) holdLeft--;
      if (go) begin
        busyLeft = CONV; holdLeft = HOLD; capM = sampleIn;
      end
      scLast = scN;
      if (pu < PWR) pu++;
    end
    #2;
    if (!done) begin
      check("R7 eocOut", eocOut, busyLeft == 0);
      check("R6 holdOut", holdOut, holdLeft > 0);
      check("R7 resultOut", resultOut, resM);
      check("R8 eocDriveEn", eocDriveEn, syncMode && !csN && !eocEnN);
      check("R9 eocPullLow", eocPullLow, !syncMode && !eocEnN && busyLeft > 0);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scPulse();
    @(negedge clk) scN = 1'b0;
    @(negedge clk) scN = 1'b1;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    cycles(4);
    check("R11 eocOut", eocOut, 1);
    check("R11 holdOut", holdOut, 0);
    check("R11 resultOut", resultOut, 0);
    check("R11 eocPullLow", eocPullLow, 0);
    @(negedge clk) rstN = 1'b1;

    // R10: start during power-up is ignored
    csN = 1'b0; sampleIn = 14'h0AAA;
    cycles(5);
    scPulse();
    cycles(2);
    check("R10 no start in power-up", eocOut, 1);
    cycles(PWR);

    // R1: synchronous start with chip select low
    sampleIn = 14'h1234;
    eocEnN = 1'b0;
    scPulse();
    sampleIn = 14'h0000;
    check("R1 started", eocOut, 0);
    check("R8 driven", eocDriveEn, 1);
    cycles(CONV + 2);
    check("R7 result", resultOut, 14'h1234);

    // R2: chip select high blocks start in synchronous mode
    csN = 1'b1;
    scPulse();
    cycles(2);
    check("R2 no start", eocOut, 1);
    check("R8 released", eocDriveEn, 0);

    // R3: asynchronous mode ignores chip select
    syncMode = 1'b0; sampleIn = 14'h2BCD;
    scPulse();
    check("R3 started", eocOut, 0);
    check("R9 pull low", eocPullLow, 1);
    // R5: second edge while running is ignored
    cycles(2);
    sampleIn = 14'h3FFF;
    scPulse();
    cycles(CONV);
    check("R5 idle after first", eocOut, 1);
    check("R5 first sample kept", resultOut, 14'h2BCD);
    check("R9 released idle", eocPullLow, 0);

    // R4: held-low start line gives one conversion only
    sampleIn = 14'h0101;
    @(negedge clk) scN = 1'b0;
    cycles(3 * CONV);
    check("R4 no repeat", eocOut, 1);
    check("R4 one result", resultOut, 14'h0101);
    @(negedge clk) scN = 1'b1;
    sampleIn = 14'h1EEE;
    scPulse();
    check("R4 fresh edge starts", eocOut, 0);
    eocEnN = 1'b1;
    cycles(1);
    check("R9 disabled", eocPullLow, 0);
    cycles(CONV + 2);

    // synchronous with csN toggling during conversion
    syncMode = 1'b1; csN = 1'b0; eocEnN = 1'b0; sampleIn = 14'h0F0F;
    scPulse();
    csN = 1'b1;
    cycles(2);
    check("R8 csN high floats", eocDriveEn, 0);
    csN = 1'b0;
    cycles(1);
    check("R8 converting value", eocOut, 0);
    cycles(CONV + 2);
    check("R7 final result", resultOut, 14'h0F0F);
    finishRun();
  end
endmodule